// File: doc/BRIEF.md
# Accumulator Fetch-Execute Sequencer

This block is a small multicycle processor core with an accumulator, a program counter, a memory address register, a memory data register and an instruction register. A control state machine moves the core through exactly one register transfer per clock. Every instruction starts with the same fetch steps and then follows its own fixed execute sequence. Because of this, the cycle count of every instruction is known in advance and each datapath move can be traced to a single state.

The core drives a synchronous single-port memory. The memory address always comes from the address register, and write data always comes from the data register. A read returns data one cycle after the address is presented. A single I/O register connects the core to the outside. An external producer loads it through a valid strobe, and the output instruction loads it from the accumulator and raises a one-cycle output strobe.

Words are 12 bits wide by default. A 4-bit opcode sits above an 8-bit operand address. The state register can be built one-hot or binary, chosen by a parameter.

Top module: `acc_seq_cpu`

## Requirements
- R1: A synchronous active-high reset clears PC, MAR, MDR, IR, the accumulator and the I/O register, and holds `halted`, `out_valid` and `mem_we` low. After reset is released, the first fetch reads address 0.
- R2: Every instruction begins with four fetch cycles, in this order: PC to MAR, a memory wait cycle, memory data to MDR, then MDR to IR. `mem_addr` always shows MAR.
- R3: An instruction word carries its opcode in bits [11:8] and its operand address in bits [7:0]. The codes are 0 halt, 1 load, 2 store, 3 add, 4 subtract, 5 input, 6 output, 7 branch, 8 branch-if-negative, 9 clear and 10 complement.
- R4: Load, add and subtract each execute five more cycles after fetch: IR address to MAR, a wait cycle, memory to MDR, the accumulator update (MDR, A+MDR or A−MDR, all modulo 2^12), then PC+1.
- R5: Store moves the IR address to MAR, then A to MDR, then raises `mem_we` for exactly one cycle with `mem_wdata` equal to A, then increments PC.
- R6: Input copies the I/O register into A. Output copies A into the I/O register, and `out_valid` is high for exactly the one following cycle, with `out_data` equal to that value. Each is followed by PC+1 and does not access memory.
- R7: `in_valid` loads `in_data` into the I/O register on any cycle except the output transfer cycle. In that cycle the accumulator value is kept and the external value is dropped.
- R8: Branch loads PC from the IR address and does not increment it.
- R9: Branch-if-negative loads PC from the IR address when bit 11 of A is set. Otherwise it increments PC.
- R10: Clear writes 0 to A. Complement writes the two's complement negation of A to A, so 0x800 stays 0x800. Each is followed by PC+1.
- R11: Opcodes 11 to 15 change nothing except PC, which is incremented.
- R12: After fetching a halt instruction, the core raises `halted` and keeps it high until reset. While halted it performs no memory write, and `mem_addr` stays at the halt instruction's address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 8 | Memory address (MAR) |
| mem_wdata | output | 12 | Memory write data (MDR) |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 12 | Memory read data, valid one cycle after the address |
| in_data | input | 12 | External value for the I/O register |
| in_valid | input | 1 | Loads `in_data` into the I/O register |
| out_data | output | 12 | I/O register contents |
| out_valid | output | 1 | One-cycle strobe after an output transfer |
| halted | output | 1 | Core has stopped on a halt instruction |

## Verification
Two writers can land on the I/O register in the same cycle: the output instruction's accumulator transfer and an external `in_valid` load. The bench provokes this by holding `in_valid` high with a fixed pattern for the whole of a program that loads a different value and outputs it. It judges the result by requiring the output strobe to carry the accumulator value. A later input instruction must then pick up the external pattern, and that value is output again. The same run fixes the cycle in which the first output strobe appears, which confirms the fetch and operand sequence lengths.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

   // opcode values (field decoded by the sequencer)
   localparam int OP_HALT  = 0;
   localparam int OP_LOAD  = 1;
   localparam int OP_STORE = 2;
   localparam int OP_ADD   = 3;
   localparam int OP_SUB   = 4;
   localparam int OP_IN    = 5;
   localparam int OP_OUT   = 6;
   localparam int OP_BR    = 7;
   localparam int OP_BRN   = 8;
   localparam int OP_CLR   = 9;
   localparam int OP_CMP   = 10;

   typedef enum logic [3:0] {
      ST_F_MAR,   // PC -> MAR
      ST_F_WAIT,  // memory read latency
      ST_F_MDR,   // memory -> MDR
      ST_F_IR,    // MDR -> IR
      ST_X_MAR,   // IR[addr] -> MAR
      ST_X_WAIT,  // memory read latency
      ST_X_MDR,   // memory -> MDR
      ST_X_ALU,   // MDR / A+MDR / A-MDR -> A
      ST_S_MDR,   // A -> MDR
      ST_S_WR,    // MDR -> memory
      ST_IO,      // IOR <-> A
      ST_ACC,     // 0 or -A -> A
      ST_BRANCH,  // IR[addr] or PC+1 -> PC
      ST_PC_INC,  // PC+1 -> PC
      ST_HALT     // stopped
   } state_e;

   localparam int NUM_STATES = 15;

   typedef enum logic [2:0] {
      A_HOLD, A_MDR, A_ADD, A_SUB, A_IOR, A_ZERO, A_NEG
   } acc_sel_e;

   typedef enum logic [1:0] { PC_HOLD, PC_INC, PC_JUMP } pc_sel_e;
   typedef enum logic [1:0] { MAR_HOLD, MAR_PC, MAR_IR } mar_sel_e;
   typedef enum logic [1:0] { MDR_HOLD, MDR_MEM, MDR_ACC } mdr_sel_e;

   typedef struct packed {
      mar_sel_e mar;
      mdr_sel_e mdr;
      logic     ir_ld;
      acc_sel_e acc;
      pc_sel_e  pc;
      logic     mem_we;
      logic     ior_ld;
   } ctl_t;

endpackage

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
   import acc_seq_pkg::*;
#(
   parameter int W = 12
) (
   input  logic [W-1:0] acc,
   input  logic [W-1:0] mdr,
   input  logic [W-1:0] ior,
   input  acc_sel_e     sel,
   output logic [W-1:0] acc_nxt
);

   always_comb begin
      unique case (sel)
         A_MDR:   acc_nxt = mdr;
         A_ADD:   acc_nxt = acc + mdr;
         A_SUB:   acc_nxt = acc - mdr;
         A_IOR:   acc_nxt = ior;
         A_ZERO:  acc_nxt = '0;
         A_NEG:   acc_nxt = (~acc) + W'(1);
         default: acc_nxt = acc;
      endcase
   end

endmodule

// File: rtl/acc_seq_ioreg.sv
module acc_seq_ioreg #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] in_data,
   input  logic         in_valid,
   input  logic         cpu_ld,
   input  logic [W-1:0] cpu_data,
   output logic [W-1:0] ior,
   output logic         out_valid
);

   always_ff @(posedge clk) begin
      if (rst) begin
         ior       <= '0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= cpu_ld;
         if (cpu_ld)
            ior <= cpu_data;      // core transfer wins a same-cycle strobe
         else if (in_valid)
            ior <= in_data;
      end
   end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
   import acc_seq_pkg::*;
#(
   parameter int OP_W    = 4,
   parameter bit ONE_HOT = 1'b1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [OP_W-1:0] mdr_op,
   input  logic [OP_W-1:0] ir_op,
   input  logic            acc_neg,
   output state_e          st,
   output ctl_t            ctl
);

   localparam int SW = $bits(state_e);

   state_e          nxt;
   logic [OP_W-1:0] op;

   // during MDR->IR the word is still in MDR
   assign op = (st == ST_F_IR) ? mdr_op : ir_op;

   function automatic logic is_op(input logic [OP_W-1:0] v, input int code);
      return v == OP_W'(code);
   endfunction

   always_comb begin
      nxt = st;
      unique case (st)
         ST_F_MAR:  nxt = ST_F_WAIT;
         ST_F_WAIT: nxt = ST_F_MDR;
         ST_F_MDR:  nxt = ST_F_IR;
         ST_F_IR: begin
            if (is_op(op, OP_HALT))
               nxt = ST_HALT;
            else if (is_op(op, OP_LOAD) || is_op(op, OP_STORE) ||
                     is_op(op, OP_ADD)  || is_op(op, OP_SUB))
               nxt = ST_X_MAR;
            else if (is_op(op, OP_IN) || is_op(op, OP_OUT))
               nxt = ST_IO;
            else if (is_op(op, OP_CLR) || is_op(op, OP_CMP))
               nxt = ST_ACC;
            else if (is_op(op, OP_BR) || is_op(op, OP_BRN))
               nxt = ST_BRANCH;
            else
               nxt = ST_PC_INC;
         end
         ST_X_MAR:  nxt = is_op(op, OP_STORE) ? ST_S_MDR : ST_X_WAIT;
         ST_X_WAIT: nxt = ST_X_MDR;
         ST_X_MDR:  nxt = ST_X_ALU;
         ST_X_ALU:  nxt = ST_PC_INC;
         ST_S_MDR:  nxt = ST_S_WR;
         ST_S_WR:   nxt = ST_PC_INC;
         ST_IO:     nxt = ST_PC_INC;
         ST_ACC:    nxt = ST_PC_INC;
         ST_BRANCH: nxt = ST_F_MAR;
         ST_PC_INC: nxt = ST_F_MAR;
         ST_HALT:   nxt = ST_HALT;
         default:   nxt = ST_F_MAR;
      endcase
   end

   always_comb begin
      ctl = '0;
      unique case (st)
         ST_F_MAR: ctl.mar = MAR_PC;
         ST_F_MDR: ctl.mdr = MDR_MEM;
         ST_F_IR:  ctl.ir_ld = 1'b1;
         ST_X_MAR: ctl.mar = MAR_IR;
         ST_X_MDR: ctl.mdr = MDR_MEM;
         ST_X_ALU: begin
            if (is_op(op, OP_ADD))      ctl.acc = A_ADD;
            else if (is_op(op, OP_SUB)) ctl.acc = A_SUB;
            else                        ctl.acc = A_MDR;
         end
         ST_S_MDR: ctl.mdr = MDR_ACC;
         ST_S_WR:  ctl.mem_we = 1'b1;
         ST_IO: begin
            if (is_op(op, OP_IN)) ctl.acc = A_IOR;
            else                  ctl.ior_ld = 1'b1;
         end
         ST_ACC:    ctl.acc = is_op(op, OP_CLR) ? A_ZERO : A_NEG;
         ST_BRANCH: begin
            if (is_op(op, OP_BR) || acc_neg) ctl.pc = PC_JUMP;
            else                             ctl.pc = PC_INC;
         end
         ST_PC_INC: ctl.pc = PC_INC;
         default:   ctl = '0;
      endcase
   end

   generate
      if (ONE_HOT) begin : g_onehot
         logic [NUM_STATES-1:0] oh_q;
         logic [SW-1:0]         idx;
         always_ff @(posedge clk) begin
            if (rst) oh_q <= NUM_STATES'(1) << ST_F_MAR;
            else     oh_q <= NUM_STATES'(1) << nxt;
         end
         always_comb begin
            idx = '0;
            for (int i = 0; i < NUM_STATES; i++)
               if (oh_q[i]) idx = SW'(i);
         end
         assign st = state_e'(idx);
      end else begin : g_binary
         state_e st_q;
         always_ff @(posedge clk) begin
            if (rst) st_q <= ST_F_MAR;
            else     st_q <= nxt;
         end
         assign st = st_q;
      end
   endgenerate

endmodule

// File: rtl/acc_seq_cpu.sv
module acc_seq_cpu
   import acc_seq_pkg::*;
#(
   parameter int ADDR_W  = 8,
   parameter int OP_W    = 4,
   parameter bit ONE_HOT = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [OP_W+ADDR_W-1:0] mem_wdata,
   output logic                   mem_we,
   input  logic [OP_W+ADDR_W-1:0] mem_rdata,
   input  logic [OP_W+ADDR_W-1:0] in_data,
   input  logic                   in_valid,
   output logic [OP_W+ADDR_W-1:0] out_data,
   output logic                   out_valid,
   output logic                   halted
);

   localparam int W = OP_W + ADDR_W;

   generate
      if (OP_W < 4) begin : g_bad_op
         $error("opcode field needs at least 4 bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address field must be non-empty");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q, mar_q;
   logic [W-1:0]      mdr_q, ir_q, acc_q, acc_nxt, ior;
   logic              ior_ld;
   state_e            st;
   ctl_t              ctl;

   acc_seq_ctrl #(.OP_W(OP_W), .ONE_HOT(ONE_HOT)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .mdr_op  (mdr_q[W-1:ADDR_W]),
      .ir_op   (ir_q[W-1:ADDR_W]),
      .acc_neg (acc_q[W-1]),
      .st      (st),
      .ctl     (ctl)
   );

   acc_seq_alu #(.W(W)) u_alu (
      .acc     (acc_q),
      .mdr     (mdr_q),
      .ior     (ior),
      .sel     (ctl.acc),
      .acc_nxt (acc_nxt)
   );

   assign ior_ld = ctl.ior_ld;

   acc_seq_ioreg #(.W(W)) u_io (
      .clk       (clk),
      .rst       (rst),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .cpu_ld    (ior_ld),
      .cpu_data  (acc_q),
      .ior       (ior),
      .out_valid (out_valid)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= '0;
         mar_q <= '0;
         mdr_q <= '0;
         ir_q  <= '0;
         acc_q <= '0;
      end else begin
         unique case (ctl.pc)
            PC_INC:  pc_q <= pc_q + ADDR_W'(1);
            PC_JUMP: pc_q <= ir_q[ADDR_W-1:0];
            default: pc_q <= pc_q;
         endcase
         unique case (ctl.mar)
            MAR_PC:  mar_q <= pc_q;
            MAR_IR:  mar_q <= ir_q[ADDR_W-1:0];
            default: mar_q <= mar_q;
         endcase
         unique case (ctl.mdr)
            MDR_MEM: mdr_q <= mem_rdata;
            MDR_ACC: mdr_q <= acc_q;
            default: mdr_q <= mdr_q;
         endcase
         if (ctl.ir_ld) ir_q <= mdr_q;
         acc_q <= acc_nxt;
      end
   end

   assign mem_addr  = mar_q;
   assign mem_wdata = mdr_q;
   assign mem_we    = ctl.mem_we;
   assign out_data  = ior;
   assign halted    = (st == ST_HALT);

endmodule

// File: rtl/acc_seq_chk.sv
module acc_seq_chk
   import acc_seq_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              mem_we,
   input logic              halted,
   input logic              out_valid,
   input logic              ior_ld,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [ADDR_W-1:0] pc,
   input state_e            st
);

   assert_reset_addr_R1: assert property (@(posedge clk)
      rst |=> (mem_addr == '0 && !halted && !out_valid));

   assert_fetch_addr_R2: assert property (@(posedge clk) disable iff (rst)
      (st == ST_F_MAR) |=> (mem_addr == $past(pc)));

   assert_write_single_R5: assert property (@(posedge clk) disable iff (rst)
      mem_we |=> !mem_we);

   assert_out_follows_R6: assert property (@(posedge clk) disable iff (rst)
      ior_ld |=> out_valid);

   assert_out_pulse_R6: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_halt_sticky_R12: assert property (@(posedge clk) disable iff (rst)
      halted |=> halted);

   assert_halt_quiet_R12: assert property (@(posedge clk) disable iff (rst)
      halted |-> !mem_we);

   assert_halt_addr_R12: assert property (@(posedge clk) disable iff (rst)
      halted |=> $stable(mem_addr));

endmodule

bind acc_seq_cpu acc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .mem_we    (mem_we),
   .halted    (halted),
   .out_valid (out_valid),
   .ior_ld    (ior_ld),
   .mem_addr  (mem_addr),
   .pc        (pc_q),
   .st        (st)
);

// File: tb/tb_acc_seq_cpu.sv
module tb_acc_seq_cpu;
   localparam int AW = 8;
   localparam int W  = 12;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [AW-1:0] mem_addr;
   logic [W-1:0]  mem_wdata, mem_rdata, in_data, out_data;
   logic          mem_we, in_valid, out_valid, halted;

   always #5 clk = ~clk;

   acc_seq_cpu dut (
      .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
      .in_valid(in_valid), .out_data(out_data), .out_valid(out_valid),
      .halted(halted)
   );

   logic [W-1:0] mem [256];
   always @(posedge clk) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      mem_rdata <= mem[mem_addr];
   end

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   int first_out = -1;

   logic [W-1:0]    q_out[$];
   string           q_tag[$];
   logic [AW+W-1:0] q_wr[$];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic exp_out(input logic [W-1:0] v, input string tag);
      q_out.push_back(v);
      q_tag.push_back(tag);
   endtask

   // monitor: pops scoreboard entries as results appear
   logic [W-1:0]    e_out;
   logic [AW+W-1:0] e_wr;
   string           e_tag;
   always @(negedge clk) begin
      if (rst) begin
         cyc = 0;
         first_out = -1;
      end else begin
         if (out_valid) begin
            if (first_out < 0) first_out = cyc;
            if (q_out.size() == 0) chk(1'b0, "R6 unexpected out_valid", int'(out_data), 0);
            else begin
               e_out = q_out.pop_front();
               e_tag = q_tag.pop_front();
               chk(out_data == e_out, e_tag, int'(out_data), int'(e_out));
            end
         end
         if (mem_we) begin
            if (q_wr.size() == 0) chk(1'b0, "R5 unexpected write", int'(mem_addr), 0);
            else begin
               e_wr = q_wr.pop_front();
               chk({mem_addr, mem_wdata} == e_wr, "R5 store addr/data",
                   int'({mem_addr, mem_wdata}), int'(e_wr));
            end
         end
         cyc++;
      end
   end

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] <= '0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state at the ports
      chk(mem_addr == '0, "R1 reset mem_addr", int'(mem_addr), 0);
      chk(!halted && !out_valid && !mem_we, "R1 reset strobes",
          int'({halted, out_valid, mem_we}), 0);
      chk(out_data == '0, "R1 reset I/O register", int'(out_data), 0);
      @(posedge clk);
      #1 rst = 1'b0;
   endtask

   task automatic wait_halt(input logic [AW-1:0] at, input string tag);
      int n = 0;
      while (!halted && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(halted, {tag, " halted reached"}, int'(halted), 1);
      repeat (12) @(negedge clk);
      chk(halted, "R12 halted stays high", int'(halted), 1);
      chk(mem_addr == at, "R12 address held at halt", int'(mem_addr), int'(at));
      chk(q_out.size() == 0, {tag, " all outputs seen"}, q_out.size(), 0);
      chk(q_wr.size() == 0, "R5 all writes seen", q_wr.size(), 0);
   endtask

   initial begin
      in_data  = '0;
      in_valid = 1'b0;

      // ---- program 1: arithmetic, branches, store, unused opcode ----
      // word = opcode[11:8] : address[7:0] (R3)
      clear_mem();
      mem[8'h00] <= 12'h500; mem[8'h01] <= 12'h380; mem[8'h02] <= 12'h600;
      mem[8'h03] <= 12'h481; mem[8'h04] <= 12'h600; mem[8'h05] <= 12'h808;
      mem[8'h06] <= 12'h600; mem[8'h07] <= 12'h000; mem[8'h08] <= 12'hA00;
      mem[8'h09] <= 12'h600; mem[8'h0A] <= 12'h282; mem[8'h0B] <= 12'h900;
      mem[8'h0C] <= 12'h806; mem[8'h0D] <= 12'h600; mem[8'h0E] <= 12'h182;
      mem[8'h0F] <= 12'h600; mem[8'h10] <= 12'hF00; mem[8'h11] <= 12'h714;
      mem[8'h12] <= 12'h600; mem[8'h13] <= 12'h000; mem[8'h14] <= 12'h183;
      mem[8'h15] <= 12'h600; mem[8'h16] <= 12'hA00; mem[8'h17] <= 12'h284;
      mem[8'h18] <= 12'h000;
      mem[8'h80] <= 12'h007; mem[8'h81] <= 12'h010; mem[8'h83] <= 12'h800;

      exp_out(12'h00C, "R4 R6 input then add");
      exp_out(12'hFFC, "R4 subtract wraps");
      exp_out(12'h004, "R9 R10 taken branch then complement");
      exp_out(12'h000, "R9 R10 clear, untaken branch");
      exp_out(12'h004, "R4 R5 load of stored word");
      exp_out(12'h800, "R8 R11 skip nop and branch");
      q_wr.push_back({8'h82, 12'h004});
      q_wr.push_back({8'h84, 12'h800});  // R10: -0x800 stays 0x800

      do_reset();
      in_data  = 12'h005;
      in_valid = 1'b1;
      @(posedge clk);
      #1 in_valid = 1'b0;
      wait_halt(8'h18, "R12 prog1");
      chk(mem[8'h82] == 12'h004, "R5 memory word 0x82", int'(mem[8'h82]), 12'h004);
      chk(mem[8'h84] == 12'h800, "R10 memory word 0x84", int'(mem[8'h84]), 12'h800);

      // ---- program 2: I/O collision and timing, reset after halt ----
      clear_mem();
      mem[8'h00] <= 12'h180; mem[8'h01] <= 12'h600; mem[8'h02] <= 12'h500;
      mem[8'h03] <= 12'h600; mem[8'h04] <= 12'h000;
      mem[8'h80] <= 12'h123;
      exp_out(12'h123, "R7 output wins over in_valid");
      exp_out(12'h3AB, "R7 external value after output");

      do_reset();
      in_data  = 12'h3AB;
      in_valid = 1'b1;
      wait_halt(8'h04, "R12 prog2");
      in_valid = 1'b0;
      // load 9 cycles, output fetch 4 + transfer 1 -> strobe in cycle 14
      chk(first_out == 14, "R2 R4 R6 first strobe cycle", first_out, 14);

      finish_up();
   end

endmodule